// File: doc/BRIEF.md
# Sharer Prediction Hint Cache

This block is a small table held privately by one core. It remembers, for recently written cache lines, which other cores held copies of each line. When the core stores to a line it holds read-only, it looks the line up here. On a hit, the core sends invalidations to the predicted sharers in parallel with its ownership request to the directory. On a miss, only the directory request goes out.

The table learns when the directory invalidates this core's copy of a line. The invalidation carries the set of cores that shared the line, and that set is recorded against the line's tag. The reasoning is that cores which read a line before a write tend to read it again afterwards.

The table is fully associative. Entries are replaced by least-recently-used order, and a free slot is always taken before a valid entry is evicted. The core's own bit is never returned as a prediction target.

Top module: `shp_hint_cache`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `rsp_valid` and `rsp_hit` are 0 and `rsp_mask` is 0. Every entry is empty after reset, so any lookup then misses.
- R2: `rsp_valid` is high in the cycle right after a cycle in which `lk_valid` was high, and low otherwise. This gives a one-cycle lookup latency.
- R3: A lookup whose tag is in no valid entry returns `rsp_hit`=0 and `rsp_mask`=0.
- R4: An update with a tag that is absent allocates an entry holding that tag and exactly `up_mask`. A later lookup of the tag hits and returns that mask.
- R5: An update with a tag that is already present ORs `up_mask` into the stored mask. Bits that were already set are kept.
- R6: Bit number `core_id` of `rsp_mask` is always 0, even when the stored mask has it set.
- R7: While any entry is empty, an allocation uses an empty entry and evicts no valid entry.
- R8: When every entry is valid, an allocation replaces the least recently used entry. An allocation or an update hit makes that entry the most recently used.
- R9: A lookup hit makes the entry the most recently used.
- R10: When a lookup and an update come in the same cycle, the lookup sees the table as it was before the update. Only the update's entry is promoted; the lookup's promotion is dropped.
- R11: In a cycle without a lookup, `rsp_hit` and `rsp_mask` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_id | input | ID_W | Index of the owning core; its bit is cleared from predictions |
| lk_valid | input | 1 | Lookup request, raised on an upgrade miss |
| lk_tag | input | TAG_W | Line tag to look up |
| up_valid | input | 1 | Update request, raised when a directory invalidation arrives |
| up_tag | input | TAG_W | Line tag being invalidated |
| up_mask | input | NODES | Sharer set carried by the invalidation |
| rsp_valid | output | 1 | Lookup result is valid this cycle |
| rsp_hit | output | 1 | Lookup found the tag |
| rsp_mask | output | NODES | Predicted sharers, own bit cleared |

## Verification
The lookup path is tried on an empty table, on an entry that was just allocated, on an entry that was grown by OR, and on a stored mask that includes the core's own bit. Together these separate a miss, a plain copy of the mask, merging and self-masking. Replacement is tried by filling the table and then inserting one more tag, once after a lookup promoted the oldest entry. This shows whether lookups count toward recency. A same-cycle lookup and update, followed by one more insertion, shows which of the two sets the order. A lookup during an update of the same tag shows that the lookup reads the contents from before the update.

// File: rtl/shp_pkg.sv
package shp_pkg;

  localparam int DEF_ENTRIES = 8;
  localparam int DEF_NODES   = 16;
  localparam int DEF_TAG_W   = 24;

  // Source of a recency promotion in a given cycle.
  typedef enum logic [1:0] {
    TOUCH_NONE   = 2'd0,
    TOUCH_LOOKUP = 2'd1,
    TOUCH_UPDATE = 2'd2
  } touch_src_e;

endpackage

// File: rtl/shp_tag_match.sv
module shp_tag_match #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 24,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               vld_i [ENTRIES],
  input  logic [TAG_W-1:0]   tag_i [ENTRIES],
  input  logic [TAG_W-1:0]   key_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o
);

  logic [ENTRIES-1:0] eq;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign eq[g] = vld_i[g] && (tag_i[g] == key_i);
    end
  endgenerate

  always_comb begin
    hit_o = |eq;
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/shp_lru.sv
module shp_lru #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic             vld_i [ENTRIES],
  output logic [IDX_W-1:0] victim_o
);

  // Each entry has an age; 0 is newest and ENTRIES-1 is oldest.
  // The ages always form a permutation of 0..ENTRIES-1.
  logic [IDX_W-1:0] age [ENTRIES];
  logic [IDX_W-1:0] touched_age;

  assign touched_age = age[touch_idx];

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_age
      always_ff @(posedge clk) begin
        if (rst) begin
          age[g] <= IDX_W'(g);
        end else if (touch_en) begin
          if (touch_idx == IDX_W'(g))
            age[g] <= '0;
          else if (age[g] < touched_age)
            age[g] <= age[g] + 1'b1;
        end
      end
    end
  endgenerate

  logic             any_free;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] old_idx;

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    old_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_i[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (age[i] == IDX_W'(ENTRIES - 1)) old_idx = IDX_W'(i);
    end
    victim_o = any_free ? free_idx : old_idx;
  end

endmodule

// File: rtl/shp_hint_cache.sv
module shp_hint_cache #(
  parameter int ENTRIES = shp_pkg::DEF_ENTRIES,
  parameter int NODES   = shp_pkg::DEF_NODES,
  parameter int TAG_W   = shp_pkg::DEF_TAG_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int ID_W   = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ID_W-1:0]  core_id,
  input  logic             lk_valid,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             up_valid,
  input  logic [TAG_W-1:0] up_tag,
  input  logic [NODES-1:0] up_mask,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [NODES-1:0] rsp_mask
);
  import shp_pkg::*;

  logic             vld   [ENTRIES];
  logic [TAG_W-1:0] tags  [ENTRIES];
  logic [NODES-1:0] masks [ENTRIES];

  logic             lk_hit, up_hit;
  logic [IDX_W-1:0] lk_idx, up_hit_idx, victim, up_idx;

  shp_tag_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_lk_match (
    .vld_i(vld), .tag_i(tags), .key_i(lk_tag), .hit_o(lk_hit), .idx_o(lk_idx)
  );

  shp_tag_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_up_match (
    .vld_i(vld), .tag_i(tags), .key_i(up_tag), .hit_o(up_hit), .idx_o(up_hit_idx)
  );

  assign up_idx = up_hit ? up_hit_idx : victim;

  // Recency promotion: the update takes priority over the lookup.
  touch_src_e       touch_src;
  logic             touch_en;
  logic [IDX_W-1:0] touch_idx;

  always_comb begin
    if (up_valid)                touch_src = TOUCH_UPDATE;
    else if (lk_valid && lk_hit) touch_src = TOUCH_LOOKUP;
    else                         touch_src = TOUCH_NONE;
    touch_en  = (touch_src != TOUCH_NONE);
    touch_idx = (touch_src == TOUCH_UPDATE) ? up_idx : lk_idx;
  end

  shp_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk(clk), .rst(rst), .touch_en(touch_en), .touch_idx(touch_idx),
    .vld_i(vld), .victim_o(victim)
  );

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_ent
      logic sel;
      assign sel = up_valid && (up_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
        if (rst)      vld[g] <= 1'b0;
        else if (sel) vld[g] <= 1'b1;
      end

      // Payload carries no reset; the valid bit guards it.
      always_ff @(posedge clk) begin
        if (sel) begin
          tags[g]  <= up_tag;
          masks[g] <= up_hit ? (masks[g] | up_mask) : up_mask;
        end
      end
    end
  endgenerate

  logic [NODES-1:0] self_bit;
  assign self_bit = NODES'(1) << core_id;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_mask  <= '0;
    end else begin
      rsp_valid <= lk_valid;
      if (lk_valid) begin
        rsp_hit  <= lk_hit;
        rsp_mask <= lk_hit ? (masks[lk_idx] & ~self_bit) : '0;
      end
    end
  end

endmodule

// File: rtl/shp_hint_cache_chk.sv
module shp_hint_cache_chk #(
  parameter int NODES = 16,
  localparam int ID_W = (NODES > 1) ? $clog2(NODES) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic [ID_W-1:0]  core_id,
  input logic             lk_valid,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [NODES-1:0] rsp_mask
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !rsp_hit && rsp_mask == '0));

  // R2
  rsp_follows_lk_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);

  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);

  // R3
  miss_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_mask == '0));

  // R6
  self_clear_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> !rsp_mask[$past(core_id)]);

  // R11
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> ($stable(rsp_mask) && $stable(rsp_hit)));

endmodule

bind shp_hint_cache shp_hint_cache_chk #(.NODES(NODES)) u_chk (
  .clk(clk), .rst(rst), .core_id(core_id), .lk_valid(lk_valid),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_mask(rsp_mask)
);

// File: tb/shp_hint_cache_tb.sv
module shp_hint_cache_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 8;
  localparam int NODES   = 16;
  localparam int TAG_W   = 24;
  localparam int ID_W    = 4;
  localparam int NVEC    = 22;

  logic             clk = 1'b0;
  logic             rst;
  logic [ID_W-1:0]  core_id;
  logic             lk_valid, up_valid;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic [NODES-1:0] up_mask;
  logic             rsp_valid, rsp_hit;
  logic [NODES-1:0] rsp_mask;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shp_hint_cache #(.ENTRIES(ENTRIES), .NODES(NODES), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst(rst), .core_id(core_id),
    .lk_valid(lk_valid), .lk_tag(lk_tag),
    .up_valid(up_valid), .up_tag(up_tag), .up_mask(up_mask),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_mask(rsp_mask)
  );

  // {lk, lk_tag, up, up_tag, up_mask, exp_hit, exp_mask}; core_id = 3
  localparam logic [50:0] VEC [NVEC] = '{
    {1'b1, 8'd1,  1'b0, 8'd0,  16'h0000, 1'b0, 16'h0000}, // R3 empty miss
    {1'b0, 8'd0,  1'b1, 8'd1,  16'h0018, 1'b0, 16'h0000}, // R4 alloc A
    {1'b1, 8'd1,  1'b0, 8'd0,  16'h0000, 1'b1, 16'h0010}, // R4 R6 own bit cleared
    {1'b0, 8'd0,  1'b1, 8'd1,  16'h0100, 1'b0, 16'h0000}, // R5 merge
    {1'b1, 8'd1,  1'b0, 8'd0,  16'h0000, 1'b1, 16'h0110}, // R5
    {1'b1, 8'd2,  1'b0, 8'd0,  16'h0000, 1'b0, 16'h0000}, // R3
    {1'b1, 8'd2,  1'b1, 8'd2,  16'h0001, 1'b0, 16'h0000}, // R10 pre-update view
    {1'b1, 8'd2,  1'b0, 8'd0,  16'h0000, 1'b1, 16'h0001}, // R4
    {1'b0, 8'd0,  1'b1, 8'd3,  16'h0020, 1'b0, 16'h0000},
    {1'b0, 8'd0,  1'b1, 8'd4,  16'h0020, 1'b0, 16'h0000},
    {1'b0, 8'd0,  1'b1, 8'd5,  16'h0020, 1'b0, 16'h0000},
    {1'b0, 8'd0,  1'b1, 8'd6,  16'h0020, 1'b0, 16'h0000},
    {1'b0, 8'd0,  1'b1, 8'd7,  16'h0020, 1'b0, 16'h0000},
    {1'b0, 8'd0,  1'b1, 8'd8,  16'h0020, 1'b0, 16'h0000},
    {1'b1, 8'd1,  1'b0, 8'd0,  16'h0000, 1'b1, 16'h0110}, // R7 A survived fill; R9 promote
    {1'b0, 8'd0,  1'b1, 8'd9,  16'h0040, 1'b0, 16'h0000}, // R8 evicts B
    {1'b1, 8'd2,  1'b0, 8'd0,  16'h0000, 1'b0, 16'h0000}, // R8 R9 B gone
    {1'b1, 8'd3,  1'b1, 8'd4,  16'h0200, 1'b1, 16'h0020}, // R10 both same cycle
    {1'b0, 8'd0,  1'b1, 8'd10, 16'h0080, 1'b0, 16'h0000}, // R10 evicts C
    {1'b1, 8'd3,  1'b0, 8'd0,  16'h0000, 1'b0, 16'h0000}, // R10 C gone
    {1'b1, 8'd5,  1'b0, 8'd0,  16'h0000, 1'b1, 16'h0020}, // R10 E kept
    {1'b1, 8'd4,  1'b0, 8'd0,  16'h0000, 1'b1, 16'h0220}  // R5
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    lk_valid = 1'b0; lk_tag = '0;
    up_valid = 1'b0; up_tag = '0; up_mask = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [50:0] v;
    idle();
    core_id = 4'd3;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rsp_valid in reset", 32'(rsp_valid), 0);
    chk("R1 rsp_mask in reset", 32'(rsp_mask), 0);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      @(negedge clk);
      lk_valid = v[50];
      lk_tag   = TAG_W'(v[49:42]);
      up_valid = v[41];
      up_tag   = TAG_W'(v[40:33]);
      up_mask  = v[32:17];
      @(posedge clk);
      #1;
      chk("R2 rsp_valid", 32'(rsp_valid), 32'(v[50]));
      if (v[50]) begin
        chk("R3 R4 R8 R9 R10 rsp_hit", 32'(rsp_hit), 32'(v[16]));
        chk("R4 R5 R6 rsp_mask", 32'(rsp_mask), 32'(v[15:0]));
      end
    end

    // R11: idle cycles keep the last result
    @(negedge clk) idle();
    repeat (2) @(posedge clk);
    #1;
    chk("R11 hold mask", 32'(rsp_mask), 32'h0220);
    chk("R11 hold hit", 32'(rsp_hit), 1);
    chk("R2 no lookup no valid", 32'(rsp_valid), 0);

    // R6 with another core id on a stored mask containing bit 5
    @(negedge clk);
    core_id = 4'd5; lk_valid = 1'b1; lk_tag = TAG_W'(5);
    @(posedge clk);
    #1;
    chk("R6 own bit cleared", 32'(rsp_mask), 32'h0000);

    // R1: reset in mid-run empties the table
    @(negedge clk) begin idle(); rst = 1'b1; end
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    chk("R1 rsp_hit after reset", 32'(rsp_hit), 0);
    chk("R1 rsp_mask after reset", 32'(rsp_mask), 0);
    @(negedge clk);
    lk_valid = 1'b1; lk_tag = TAG_W'(1);
    @(posedge clk);
    #1;
    chk("R1 table empty after reset", 32'(rsp_hit), 0);
    @(negedge clk) idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule